// File: doc/BRIEF.md
# ECC Single-Error Threshold Control Register

This block is one memory-mapped control word for the error-correction logic of a flash controller. It holds an 8-bit start value for a count of single-error-correction (SEC) events and two kill bits that turn correction off, one for the main array and one for the data-flash region. Inside sits a down-counter that software loads by writing the count field. Each qualifying SEC event lowers the counter by one. Once the counter has run out, every further SEC event raises a sticky interrupt flag.

Software reads and writes the word through a small register port. A write-protect input blocks writes. The decoder feeds one SEC pulse per region. An interrupt clear pulse drops the flag. The two kill bits are also driven out as plain outputs, so the correction datapath can see them.

Top module: `ecc_thr_ctrl`

## Requirements
- R1: After reset the word at address 0x080 reads as all zeros, `sec_irq` is 0 and both disable outputs are 0.
- R2: At address 0x080, bits 15:8 read the programmed count start value, bit 1 reads the data-flash disable bit and bit 0 reads the main-array disable bit. All other bits read 0. Any other address reads 0, and writes to other addresses change nothing.
- R3: A write to the word loads bits 15:8 into the internal counter. Each qualifying SEC event while the counter is nonzero lowers it by one and leaves `sec_irq` unchanged.
- R4: The counter holds at zero and never wraps. It is not reloaded from the start value when it reaches zero, and the start value still reads back unchanged.
- R5: A qualifying SEC event while the counter is zero sets `sec_irq` one cycle later. The flag stays set until `irq_clr` is pulsed.
- R6: Writing 1 to bit 0 or bit 1 sets that disable bit. Writing 0 leaves it as it is. Once set, a bit clears only on reset.
- R7: While `wr_prot` is high, writes are ignored: the readback and the disable outputs do not change.
- R8: If a write and a qualifying SEC event fall in the same cycle, the write wins. The counter takes the written value and the event neither lowers the counter nor sets the flag.
- R9: If a flag set condition and `irq_clr` fall in the same cycle, the flag ends up set.
- R10: An SEC event is qualifying only if its region's ECC is still enabled. Events from disabled regions neither lower the counter nor set the flag. Pulses from both regions in the same cycle count as a single event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Register byte address, used for both read and write |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from `bus_addr`) |
| wr_prot | input | 1 | Write-protect; high blocks all writes |
| sec_main | input | 1 | SEC event pulse from the main array |
| sec_dflash | input | 1 | SEC event pulse from the data-flash region |
| irq_clr | input | 1 | Clears the SEC interrupt flag |
| sec_irq | output | 1 | Sticky SEC-over-threshold interrupt flag |
| ecc_off_main | output | 1 | Main-array ECC disabled |
| ecc_off_dflash | output | 1 | Data-flash ECC disabled |

## Verification
The internal counter cannot be read, so its value is the hardest thing to see from the ports. The bench infers it by loading a known count and then sending SEC events one at a time, checking the flag after each one. The flag must stay low for exactly the loaded number of events and rise on the next one. Collisions are tested the same way: a write in the same cycle as an event, two simultaneous region pulses, and pulses from a disabled region. After each of these, the bench counts how many further events it takes to raise the flag, which shows what the counter was left holding.

// File: rtl/ecc_thr_pkg.sv
`timescale 1ns/1ps
package ecc_thr_pkg;
    localparam int CNT_W        = 8;
    localparam int DATA_W       = 32;
    localparam int ADDR_W       = 12;
    localparam int CNT_LSB      = 8;
    localparam int OFF_MAIN_BIT = 0;
    localparam int OFF_DF_BIT   = 1;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 12'h080;

    typedef struct packed {
        logic [CNT_W-1:0] start;
        logic             off_df;
        logic             off_main;
    } ctrl_t;

    typedef struct packed {
        logic main;
        logic df;
    } sec_t;

    function automatic logic [DATA_W-1:0] pack_ctrl(ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CNT_LSB +: CNT_W] = c.start;
        w[OFF_DF_BIT]       = c.off_df;
        w[OFF_MAIN_BIT]     = c.off_main;
        return w;
    endfunction

    // Disable bits only accumulate; the count field is replaced.
    function automatic ctrl_t merge_write(ctrl_t cur, logic [DATA_W-1:0] wd);
        ctrl_t n;
        n.start    = wd[CNT_LSB +: CNT_W];
        n.off_df   = cur.off_df   | wd[OFF_DF_BIT];
        n.off_main = cur.off_main | wd[OFF_MAIN_BIT];
        return n;
    endfunction
endpackage

// File: rtl/ecc_thr_regs.sv
`timescale 1ns/1ps
module ecc_thr_regs
    import ecc_thr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl_q
);
    always_ff @(posedge clk) begin
        if (rst)         ctrl_q <= '0;
        else if (wr_hit) ctrl_q <= merge_write(ctrl_q, wdata);
    end

    // R6
    off_main_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.off_main |=> ctrl_q.off_main);
    // R6
    off_df_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.off_df |=> ctrl_q.off_df);
endmodule

// File: rtl/ecc_thr_gate.sv
`timescale 1ns/1ps
module ecc_thr_gate
    import ecc_thr_pkg::*;
(
    input  sec_t  sec_in,
    input  ctrl_t ctrl,
    output logic  evt
);
    sec_t live;
    always_comb begin
        live.main = sec_in.main & ~ctrl.off_main;
        live.df   = sec_in.df   & ~ctrl.off_df;
        evt       = |live;
    end

    // R10
    gate_off_chk: assert final ((ctrl.off_main && ctrl.off_df) -> !evt);
endmodule

// File: rtl/ecc_thr_counter.sv
`timescale 1ns/1ps
module ecc_thr_counter
    import ecc_thr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         evt,
    input  logic         clr,
    output logic         flag
);
    logic [W-1:0] cnt;
    logic         at_zero;
    logic         set_cond;

    always_comb begin
        at_zero  = (cnt == '0);
        set_cond = evt && !load && at_zero;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            flag <= 1'b0;
        end else begin
            if (load)                cnt <= load_val;
            else if (evt && !at_zero) cnt <= cnt - 1'b1;
            if (set_cond)            flag <= 1'b1;
            else if (clr)            flag <= 1'b0;
        end
    end

    // R4
    cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt == '0) |=> cnt == '0);
    // R8
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> cnt == $past(load_val));
    // R5
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        (evt && !load && cnt == '0) |=> flag);
    // R5
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);
endmodule

// File: rtl/ecc_thr_ctrl.sv
`timescale 1ns/1ps
module ecc_thr_ctrl
    import ecc_thr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              wr_prot,
    input  logic              sec_main,
    input  logic              sec_dflash,
    input  logic              irq_clr,
    output logic              sec_irq,
    output logic              ecc_off_main,
    output logic              ecc_off_dflash
);
    logic  sel;
    logic  wr_hit;
    logic  evt;
    ctrl_t ctrl_q;
    sec_t  sec_in;

    always_comb begin
        sel          = (bus_addr == CTRL_ADDR);
        wr_hit       = sel && bus_we && !wr_prot;
        sec_in.main  = sec_main;
        sec_in.df    = sec_dflash;
        bus_rdata    = sel ? pack_ctrl(ctrl_q) : '0;
        ecc_off_main   = ctrl_q.off_main;
        ecc_off_dflash = ctrl_q.off_df;
    end

    ecc_thr_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_hit (wr_hit),
        .wdata  (bus_wdata),
        .ctrl_q (ctrl_q)
    );

    ecc_thr_gate u_gate (
        .sec_in (sec_in),
        .ctrl   (ctrl_q),
        .evt    (evt)
    );

    ecc_thr_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (wr_hit),
        .load_val (bus_wdata[CNT_LSB +: CNT_W]),
        .evt      (evt),
        .clr      (irq_clr),
        .flag     (sec_irq)
    );

    // R7
    prot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        wr_prot |=> $stable(ctrl_q));
    // R2
    other_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr != CTRL_ADDR) |=> $stable(ctrl_q));
endmodule

// File: tb/sim_ecc_thr_ctrl.sv
`timescale 1ns/1ps
module sim_ecc_thr_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        wr_prot, sec_main, sec_dflash, irq_clr;
    logic        sec_irq, ecc_off_main, ecc_off_dflash;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    ecc_thr_ctrl u0 (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; bus_we = 0; bus_addr = 12'h080; bus_wdata = 0;
        wr_prot = 0; sec_main = 0; sec_dflash = 0; irq_clr = 0;
        repeat (2) @(negedge clk);
        rst = 0;
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1;
        @(negedge clk);
        bus_we = 0; bus_addr = 12'h080;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        bus_addr = a; #0.5 d = bus_rdata; bus_addr = 12'h080;
    endtask

    task automatic pulse(logic m, logic f);
        sec_main = m; sec_dflash = f;
        @(negedge clk);
        sec_main = 0; sec_dflash = 0;
    endtask

    task automatic clear_irq();
        irq_clr = 1; @(negedge clk); irq_clr = 0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        rd(12'h080, d);
        chk("R1 readback", d, 0);
        chk("R1 irq", sec_irq, 0);
        chk("R1 off", {ecc_off_dflash, ecc_off_main}, 0);
    endtask

    task automatic t_layout();
        logic [31:0] d;
        do_reset();
        wr(12'h080, 32'hFFFF_A5FC);
        rd(12'h080, d);
        chk("R2 layout", d, 32'h0000_A500);
        rd(12'h084, d);
        chk("R2 other addr read", d, 0);
        wr(12'h084, 32'h0000_3303);
        rd(12'h080, d);
        chk("R2 other addr write", d, 32'h0000_A500);
    endtask

    task automatic t_count();
        logic [31:0] d;
        do_reset();
        wr(12'h080, 32'h0000_0300);
        for (int i = 0; i < 3; i++) begin
            pulse(1, 0);
            chk("R3 no irq while nonzero", sec_irq, 0);
        end
        pulse(0, 1);
        chk("R5 irq at zero", sec_irq, 1);
        repeat (3) @(negedge clk);
        chk("R5 irq sticky", sec_irq, 1);
        clear_irq();
        chk("R5 irq cleared", sec_irq, 0);
        pulse(1, 0);
        chk("R4 no reload, still zero", sec_irq, 1);
        rd(12'h080, d);
        chk("R4 start value kept", d, 32'h0000_0300);
    endtask

    task automatic t_prot();
        logic [31:0] d;
        do_reset();
        wr(12'h080, 32'h0000_0200);
        wr_prot = 1;
        wr(12'h080, 32'h0000_7F03);
        wr_prot = 0;
        rd(12'h080, d);
        chk("R7 protected write", d, 32'h0000_0200);
        chk("R7 off outputs", {ecc_off_dflash, ecc_off_main}, 0);
    endtask

    task automatic t_collide();
        do_reset();
        sec_main = 1;
        wr(12'h080, 32'h0000_0200);
        sec_main = 0;
        pulse(1, 0);
        pulse(1, 0);
        chk("R8 write won, count 2", sec_irq, 0);
        pulse(1, 0);
        chk("R8 irq after 3rd", sec_irq, 1);
        // R8: event at zero with a write in the same cycle sets nothing
        do_reset();
        sec_main = 1;
        wr(12'h080, 32'h0000_0000);
        sec_main = 0;
        chk("R8 no flag on write cycle", sec_irq, 0);
    endtask

    task automatic t_set_clr();
        do_reset();
        pulse(1, 0);
        chk("R9 setup", sec_irq, 1);
        irq_clr = 1; sec_main = 1;
        @(negedge clk);
        irq_clr = 0; sec_main = 0;
        chk("R9 set beats clear", sec_irq, 1);
    endtask

    task automatic t_both();
        do_reset();
        wr(12'h080, 32'h0000_0200);
        pulse(1, 1);
        chk("R10 both count once", sec_irq, 0);
        pulse(1, 0);
        chk("R10 second event", sec_irq, 0);
        pulse(1, 0);
        chk("R10 irq after third", sec_irq, 1);
    endtask

    task automatic t_disable();
        logic [31:0] d;
        do_reset();
        wr(12'h080, 32'h0000_0001);
        chk("R6 main off set", ecc_off_main, 1);
        wr(12'h080, 32'h0000_0000);
        chk("R6 write 0 no clear", ecc_off_main, 1);
        chk("R6 df untouched", ecc_off_dflash, 0);
        pulse(1, 0);
        chk("R10 disabled main ignored", sec_irq, 0);
        wr(12'h080, 32'h0000_0102);
        rd(12'h080, d);
        chk("R6 both off read", d, 32'h0000_0103);
        pulse(1, 1);
        pulse(0, 1);
        chk("R10 all disabled ignored", sec_irq, 0);
        do_reset();
        chk("R6 reset clears", {ecc_off_dflash, ecc_off_main}, 0);
    endtask

    initial begin
        rst = 1; bus_we = 0; bus_addr = 0; bus_wdata = 0;
        wr_prot = 0; sec_main = 0; sec_dflash = 0; irq_clr = 0;
        t_reset();
        t_layout();
        t_count();
        t_prot();
        t_collide();
        t_set_clr();
        t_both();
        t_disable();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule